// File: doc/BRIEF.md
# Segment Selector Check and Descriptor Load

This block performs the two halves of loading a protected-mode segment register. On its request channel it takes a 16-bit selector and an access size, picks the local or global descriptor table from the selector's table-indicator bit, and forms the memory address of the descriptor. It also decides whether that access would run past the table's limit or use an unusable local table. The result comes back on a registered response channel. It carries the address, a general-protection fault flag with its error code, and a flag that marks a null selector.

On its descriptor channel it takes the 64-bit descriptor word that was fetched from that address. It reassembles the split base and limit fields and applies granularity scaling to the limit. It derives the segment attributes, which follow separate rules for code and data segments, and stores base, limit and attributes in the segment registers. A system descriptor or a not-present descriptor is refused: the segment registers keep their old contents and an error pulse is raised.

The request channel uses valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever the response slot is empty or is being drained in the same cycle. While `rsp_valid` is high and `rsp_ready` is low, the response payload is held steady and no new request is taken. The descriptor channel never stalls, so `desc_ready` is tied high.

Top module: `segld_top`

## Requirements
- R1: The selector index is bits 15:3 and the table indicator is bit 2. `rsp_addr` equals `ldt_base` + index·8 when the indicator is 1, and `gdt_base` + index·8 when it is 0.
- R2: `rsp_fault` is 1 when index·8 + `req_size` is greater than the selected table's limit. Equality is not a fault.
- R3: `rsp_fault` is 1 when the table indicator is 1 while `ldt_sel` is zero.
- R4: `rsp_code` always equals the 16-bit selector of the request.
- R5: `rsp_null` is 1 only when `null_en` is 1 and both the index and the table indicator are zero. Otherwise it is 0.
- R6: A request accepted at a clock edge shows on the response outputs right after that edge. `req_ready` is `!rsp_valid || rsp_ready`. A stalled response holds all of its fields.
- R7: Descriptor layout: limit at 15:0 and 51:48, base at 39:16 and 63:56, type at 43:40, S at 44, privilege at 46:45, P at 47, L at 53, D at 54, G at 55. `seg_base` is bits 39:16 OR (bits 63:56 << 24).
- R8: `seg_limit` is bits 15:0 OR (bits 51:48 << 16). When G=1 this value is shifted left by 12 and the low 12 bits are filled with ones.
- R9: `seg_attr` bits: 0 readable, 1 writable, 2 expand-down, 3 code, 4 long mode, 5 default size (D), 7:6 privilege level. D and the privilege level are copied from the descriptor.
- R10: A code segment (type bit 3 = 1) takes readable from type bit 1 and long mode from L. Writable and expand-down are 0.
- R11: A data segment (type bit 3 = 0) is always readable. Writable comes from type bit 1, expand-down from type bit 2, and long mode is 0.
- R12: A descriptor with S=0 or P=0 leaves `seg_base`, `seg_limit` and `seg_attr` unchanged, and `desc_err` is 1 for the cycle after. A good descriptor updates the registers at the edge where it is presented.
- R13: After reset, `rsp_valid`, `desc_err` and all segment registers are 0, and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gdt_base | input | ADDR_W | Global table base address |
| gdt_limit | input | LIM_W | Global table limit |
| ldt_base | input | ADDR_W | Local table base address |
| ldt_limit | input | LIM_W | Local table limit |
| ldt_sel | input | 16 | Selector held in the local table register |
| req_valid | input | 1 | Selector request valid |
| req_ready | output | 1 | Selector request accepted |
| req_sel | input | 16 | Selector to check |
| req_size | input | SIZE_W | Access size in bytes |
| null_en | input | 1 | Enable for the null-selector flag |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumed |
| rsp_addr | output | ADDR_W | Descriptor address |
| rsp_fault | output | 1 | General-protection fault |
| rsp_code | output | 16 | Fault error code |
| rsp_null | output | 1 | Null-selector flag |
| desc_valid | input | 1 | Descriptor word valid |
| desc_ready | output | 1 | Descriptor accepted (always 1) |
| desc_word | input | 64 | Fetched descriptor |
| seg_base | output | 32 | Segment base register |
| seg_limit | output | 32 | Segment limit register |
| seg_attr | output | 8 | Segment attribute register |
| desc_err | output | 1 | Descriptor refused, one-cycle pulse |

## Verification
The bench places accesses exactly at the table limit and one byte past it. A design that uses greater-or-equal faults on a legal last entry, and one with too narrow a sum misses the fault at the top. Selectors with a zero index are sent with the table indicator both clear and set, and with the null enable off. A design that ignores the indicator or the enable flags the local entry 0 as null. Descriptors with G set, and both code and data types, expose a missing fill of the low twelve bits or swapped type-bit rules. S=0 and P=0 descriptors sent after a good load show whether a refused descriptor overwrites the registers. A stalled response with a second request waiting exposes lost or overwritten responses.

// File: rtl/segld_pkg.sv
`timescale 1ns/1ps
package segld_pkg;
  localparam int SEL_W  = 16;
  localparam int DESC_W = 64;
  localparam int SEG_W  = 32;
  localparam int IDX_LSB = 3;
  localparam int TI_BIT  = 2;

  // descriptor field positions (the decoder depends on them)
  localparam int D_TYPE_LO = 40;
  localparam int D_S_BIT   = 44;
  localparam int D_DPL_LO  = 45;
  localparam int D_P_BIT   = 47;
  localparam int D_L_BIT   = 53;
  localparam int D_D_BIT   = 54;
  localparam int D_G_BIT   = 55;

  typedef struct packed {
    logic [1:0] dpl;
    logic       def_size;
    logic       long_mode;
    logic       is_code;
    logic       expand_down;
    logic       writable;
    logic       readable;
  } seg_attr_t;
endpackage

// File: rtl/segld_sel_check.sv
`timescale 1ns/1ps
module segld_sel_check
  import segld_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int LIM_W  = 32,
  parameter int SIZE_W = 4
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic [SIZE_W-1:0] size,
  input  logic              null_en,
  input  logic [ADDR_W-1:0] gdt_base,
  input  logic [LIM_W-1:0]  gdt_limit,
  input  logic [ADDR_W-1:0] ldt_base,
  input  logic [LIM_W-1:0]  ldt_limit,
  input  logic [SEL_W-1:0]  ldt_sel,
  output logic [ADDR_W-1:0] addr,
  output logic              fault,
  output logic              is_null
);
  localparam int IDX_W  = SEL_W - IDX_LSB;
  localparam int SPAN_W = LIM_W + 1;

  logic [IDX_W-1:0]   idx;
  logic               ti;
  logic [SEL_W-1:0]   offs;
  logic [ADDR_W-1:0]  tbl_base;
  logic [LIM_W-1:0]   tbl_lim;
  logic [SPAN_W-1:0]  span;
  logic               over_lim;
  logic               ldt_unusable;

  assign idx  = sel[SEL_W-1:IDX_LSB];
  assign ti   = sel[TI_BIT];
  assign offs = {idx, {IDX_LSB{1'b0}}};

  assign tbl_base = ti ? ldt_base  : gdt_base;
  assign tbl_lim  = ti ? ldt_limit : gdt_limit;

  assign addr = tbl_base + ADDR_W'(offs);

  // one extra bit so index*8 + size never wraps
  assign span     = SPAN_W'(offs) + SPAN_W'(size);
  assign over_lim = span > {1'b0, tbl_lim};

  assign ldt_unusable = ti && (ldt_sel == '0);
  assign fault        = over_lim || ldt_unusable;

  assign is_null = null_en && (idx == '0) && !ti;
endmodule

// File: rtl/segld_desc_decode.sv
`timescale 1ns/1ps
module segld_desc_decode
  import segld_pkg::*;
(
  input  logic [DESC_W-1:0] desc,
  output logic [SEG_W-1:0]  base,
  output logic [SEG_W-1:0]  limit,
  output seg_attr_t         attr,
  output logic              bad
);
  localparam int RAW_LIM_W = 20;
  localparam int GRAN_SH   = SEG_W - RAW_LIM_W;

  logic [RAW_LIM_W-1:0] raw_lim;
  logic [3:0]           typ;
  logic                 code_seg;

  assign raw_lim = {desc[51:48], desc[15:0]};
  assign base    = {desc[63:56], desc[39:16]};
  assign limit   = desc[D_G_BIT] ? {raw_lim, {GRAN_SH{1'b1}}}
                                 : {{GRAN_SH{1'b0}}, raw_lim};

  assign typ      = desc[D_TYPE_LO +: 4];
  assign code_seg = typ[3];

  always_comb begin
    attr          = '0;
    attr.dpl      = desc[D_DPL_LO +: 2];
    attr.def_size = desc[D_D_BIT];
    attr.is_code  = code_seg;
    if (code_seg) begin
      attr.readable  = typ[1];
      attr.long_mode = desc[D_L_BIT];
    end else begin
      attr.readable    = 1'b1;
      attr.writable    = typ[1];
      attr.expand_down = typ[2];
    end
  end

  assign bad = !desc[D_S_BIT] || !desc[D_P_BIT];
endmodule

// File: rtl/segld_pipe.sv
`timescale 1ns/1ps
module segld_pipe #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end
endmodule

// File: rtl/segld_top.sv
`timescale 1ns/1ps
module segld_top
  import segld_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int LIM_W  = 32,
  parameter int SIZE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] gdt_base,
  input  logic [LIM_W-1:0]  gdt_limit,
  input  logic [ADDR_W-1:0] ldt_base,
  input  logic [LIM_W-1:0]  ldt_limit,
  input  logic [SEL_W-1:0]  ldt_sel,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SEL_W-1:0]  req_sel,
  input  logic [SIZE_W-1:0] req_size,
  input  logic              null_en,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic              rsp_fault,
  output logic [SEL_W-1:0]  rsp_code,
  output logic              rsp_null,
  input  logic              desc_valid,
  output logic              desc_ready,
  input  logic [DESC_W-1:0] desc_word,
  output logic [SEG_W-1:0]  seg_base,
  output logic [SEG_W-1:0]  seg_limit,
  output logic [7:0]        seg_attr,
  output logic              desc_err
);
  localparam int PAY_W = ADDR_W + 1 + SEL_W + 1;

  logic [ADDR_W-1:0] chk_addr;
  logic              chk_fault;
  logic              chk_null;
  logic [PAY_W-1:0]  pay_in;
  logic [PAY_W-1:0]  pay_out;

  segld_sel_check #(.ADDR_W(ADDR_W), .LIM_W(LIM_W), .SIZE_W(SIZE_W)) u_sel (
    .sel       (req_sel),
    .size      (req_size),
    .null_en   (null_en),
    .gdt_base  (gdt_base),
    .gdt_limit (gdt_limit),
    .ldt_base  (ldt_base),
    .ldt_limit (ldt_limit),
    .ldt_sel   (ldt_sel),
    .addr      (chk_addr),
    .fault     (chk_fault),
    .is_null   (chk_null)
  );

  assign pay_in = {chk_addr, chk_fault, req_sel, chk_null};

  segld_pipe #(.W(PAY_W)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_data   (pay_in),
    .out_valid (rsp_valid),
    .out_ready (rsp_ready),
    .out_data  (pay_out)
  );

  assign {rsp_addr, rsp_fault, rsp_code, rsp_null} = pay_out;

  logic [SEG_W-1:0] dec_base;
  logic [SEG_W-1:0] dec_limit;
  seg_attr_t        dec_attr;
  logic             dec_bad;

  segld_desc_decode u_dec (
    .desc  (desc_word),
    .base  (dec_base),
    .limit (dec_limit),
    .attr  (dec_attr),
    .bad   (dec_bad)
  );

  assign desc_ready = 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seg_base  <= '0;
      seg_limit <= '0;
      seg_attr  <= '0;
      desc_err  <= 1'b0;
    end else begin
      desc_err <= desc_valid && dec_bad;
      if (desc_valid && !dec_bad) begin
        seg_base  <= dec_base;
        seg_limit <= dec_limit;
        seg_attr  <= dec_attr;
      end
    end
  end
endmodule

// File: rtl/segld_chk.sv
`timescale 1ns/1ps
module segld_chk #(
  parameter int ADDR_W = 48
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [ADDR_W-1:0] rsp_addr,
  input logic              rsp_fault,
  input logic [15:0]       rsp_code,
  input logic              rsp_null,
  input logic              desc_valid,
  input logic [63:0]       desc_word,
  input logic [31:0]       seg_base,
  input logic [31:0]       seg_limit,
  input logic [7:0]        seg_attr,
  input logic              desc_err
);
  logic d_ok;
  assign d_ok = desc_word[44] && desc_word[47];

  // R6: empty slot always takes a request
  p_ready_when_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> req_ready);

  // R6: stalled response holds
  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_addr) && $stable(rsp_fault)
                                && $stable(rsp_code) && $stable(rsp_null));

  // R5: null flag only for index 0 in the global table
  p_null_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_null |-> rsp_code[15:2] == 14'd0);

  // R12: refused descriptor keeps registers and pulses error
  p_bad_keeps_r12: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && !d_ok |=> desc_err && $stable(seg_base) && $stable(seg_limit)
                            && $stable(seg_attr));

  // R8: granularity fills the low twelve bits
  p_gran_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && d_ok && desc_word[55] |=> seg_limit[11:0] == 12'hFFF);

  // R11: data segments are readable and never long
  p_data_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && d_ok && !desc_word[43] |=> seg_attr[0] && !seg_attr[4] && !seg_attr[3]);

  // R10: code segments are neither writable nor expand-down
  p_code_nowr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && d_ok && desc_word[43] |=> !seg_attr[1] && !seg_attr[2] && seg_attr[3]);

  // R12: good descriptor gives no error
  p_good_noerr_r12: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && d_ok |=> !desc_err);
endmodule

bind segld_top segld_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_addr   (rsp_addr),
  .rsp_fault  (rsp_fault),
  .rsp_code   (rsp_code),
  .rsp_null   (rsp_null),
  .desc_valid (desc_valid),
  .desc_word  (desc_word),
  .seg_base   (seg_base),
  .seg_limit  (seg_limit),
  .seg_attr   (seg_attr),
  .desc_err   (desc_err)
);

// File: tb/tb_segld_top.sv
`timescale 1ns/1ps
module tb_segld_top;
  localparam int ADDR_W = 48;
  localparam int LIM_W  = 32;
  localparam int SIZE_W = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] gdt_base = 48'h1000;
  logic [LIM_W-1:0]  gdt_limit = 32'h00FF;
  logic [ADDR_W-1:0] ldt_base = 48'h8000_0000;
  logic [LIM_W-1:0]  ldt_limit = 32'h003F;
  logic [15:0]       ldt_sel = 16'h0028;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [15:0]       req_sel = '0;
  logic [SIZE_W-1:0] req_size = '0;
  logic              null_en = 1'b0;
  logic              rsp_valid;
  logic              rsp_ready = 1'b1;
  logic [ADDR_W-1:0] rsp_addr;
  logic              rsp_fault;
  logic [15:0]       rsp_code;
  logic              rsp_null;
  logic              desc_valid = 1'b0;
  logic              desc_ready;
  logic [63:0]       desc_word = '0;
  logic [31:0]       seg_base;
  logic [31:0]       seg_limit;
  logic [7:0]        seg_attr;
  logic              desc_err;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  segld_top #(.ADDR_W(ADDR_W), .LIM_W(LIM_W), .SIZE_W(SIZE_W)) dut (.*);

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // {sel, size, null_en, exp_addr, exp_fault, exp_null}
  localparam logic [70:0] VEC [0:8] = '{
    {16'h0008, 4'd8, 1'b1, 48'h0000_0000_1008, 1'b0, 1'b0},
    {16'h0000, 4'd8, 1'b1, 48'h0000_0000_1000, 1'b0, 1'b1},
    {16'h0003, 4'd8, 1'b0, 48'h0000_0000_1000, 1'b0, 1'b0},
    {16'h00F8, 4'd8, 1'b1, 48'h0000_0000_10F8, 1'b1, 1'b0},
    {16'h00F0, 4'd8, 1'b1, 48'h0000_0000_10F0, 1'b0, 1'b0},
    {16'h00F8, 4'd7, 1'b1, 48'h0000_0000_10F8, 1'b0, 1'b0},
    {16'h000C, 4'd8, 1'b1, 48'h0000_8000_0008, 1'b0, 1'b0},
    {16'h003C, 4'd8, 1'b1, 48'h0000_8000_0038, 1'b1, 1'b0},
    {16'h0004, 4'd8, 1'b1, 48'h0000_8000_0000, 1'b0, 1'b0}
  };

  function automatic logic [63:0] mk_desc(input logic [31:0] b, input logic [19:0] l,
      input logic [3:0] t, input logic s, input logic [1:0] dpl, input logic p,
      input logic lbit, input logic dbit, input logic g);
    return {b[31:24], g, dbit, lbit, 1'b0, l[19:16], p, dpl, s, t, b[23:0], l[15:0]};
  endfunction

  task automatic send_req(input logic [15:0] s, input logic [3:0] sz, input logic ne);
    @(negedge clk);
    req_valid = 1'b1; req_sel = s; req_size = sz; null_en = ne;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic send_desc(input logic [63:0] d);
    @(negedge clk);
    desc_valid = 1'b1; desc_word = d;
    @(negedge clk);
    desc_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R13 reset state
    check("R13 rsp_valid", 64'(rsp_valid), 64'd0);
    check("R13 req_ready", 64'(req_ready), 64'd1);
    check("R13 seg_base", 64'(seg_base), 64'd0);
    check("R13 seg_limit", 64'(seg_limit), 64'd0);
    check("R13 seg_attr", 64'(seg_attr), 64'd0);
    check("R13 desc_err", 64'(desc_err), 64'd0);

    // vector table: R1 R2 R4 R5 R6
    for (int i = 0; i < 9; i++) begin
      send_req(VEC[i][70:55], VEC[i][54:51], VEC[i][50]);
      check("R6 rsp_valid", 64'(rsp_valid), 64'd1);
      check("R1 addr", 64'(rsp_addr), 64'(VEC[i][49:2]));
      check("R2 fault", 64'(rsp_fault), 64'(VEC[i][1]));
      check("R5 null", 64'(rsp_null), 64'(VEC[i][0]));
      check("R4 code", 64'(rsp_code), 64'(VEC[i][70:55]));
    end

    // R3: local table with zero selector register
    ldt_sel = 16'h0000;
    send_req(16'h000C, 4'd8, 1'b1);
    check("R3 ldt unusable fault", 64'(rsp_fault), 64'd1);
    check("R4 code on fault", 64'(rsp_code), 64'h000C);
    ldt_sel = 16'h0028;
    send_req(16'h000C, 4'd8, 1'b1);
    check("R3 ldt usable", 64'(rsp_fault), 64'd0);

    // R6: back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_sel = 16'h0008; req_size = 4'd8;
    @(negedge clk);
    req_sel = 16'h000C;
    check("R6 stall ready low", 64'(req_ready), 64'd0);
    check("R6 first held", 64'(rsp_addr), 64'h1008);
    @(negedge clk);
    check("R6 still held", 64'(rsp_addr), 64'h1008);
    check("R6 still valid", 64'(rsp_valid), 64'd1);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R6 second delivered", 64'(rsp_addr), 64'h8000_0008);
    @(negedge clk);
    check("R6 drained", 64'(rsp_valid), 64'd0);

    // descriptors: R7..R11
    send_desc(mk_desc(32'h1234_5678, 20'hABCDE, 4'b1010, 1'b1, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0));
    check("R7 base code", 64'(seg_base), 64'h1234_5678);
    check("R8 limit bytes", 64'(seg_limit), 64'h000A_BCDE);
    check("R10 code attr", 64'(seg_attr), 64'hD9);
    check("R12 no err", 64'(desc_err), 64'd0);

    send_desc(mk_desc(32'hFEDC_BA98, 20'h00012, 4'b0110, 1'b1, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1));
    check("R7 base data", 64'(seg_base), 64'hFEDC_BA98);
    check("R8 limit gran", 64'(seg_limit), 64'h0001_2FFF);
    check("R11 data attr", 64'(seg_attr), 64'h27);

    send_desc(mk_desc(32'h0000_0000, 20'hFFFFF, 4'b0000, 1'b1, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1));
    check("R8 limit max", 64'(seg_limit), 64'hFFFF_FFFF);
    check("R9 dpl data ro", 64'(seg_attr), 64'h81);

    send_desc(mk_desc(32'h0040_0000, 20'h00FFF, 4'b1000, 1'b1, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0));
    check("R10 exec only", 64'(seg_attr), 64'h68);
    check("R7 base mid", 64'(seg_base), 64'h0040_0000);

    // R12: system and not-present descriptors refused
    send_desc(mk_desc(32'hDEAD_BEEF, 20'h11111, 4'b0010, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0));
    check("R12 err S=0", 64'(desc_err), 64'd1);
    check("R12 base kept S=0", 64'(seg_base), 64'h0040_0000);
    check("R12 limit kept S=0", 64'(seg_limit), 64'h0000_0FFF);
    check("R12 attr kept S=0", 64'(seg_attr), 64'h68);
    send_desc(mk_desc(32'hCAFE_F00D, 20'h22222, 4'b0010, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1));
    check("R12 err P=0", 64'(desc_err), 64'd1);
    check("R12 base kept P=0", 64'(seg_base), 64'h0040_0000);
    check("R12 limit kept P=0", 64'(seg_limit), 64'h0000_0FFF);
    @(negedge clk);
    check("R12 err pulse ends", 64'(desc_err), 64'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule